// File: doc/BRIEF.md
# Quad Batch Assembler

This block takes 2x2 pixel quads from several parallel rasterizer streams and packs them into shading batches of 32 threads, one thread per pixel. A quad carries its screen position, a four-bit coverage mask and the identifier of the shader program that will run on it. All four pixels of an accepted quad take a thread slot. Pixels whose coverage bit is clear still run as helper threads, so the shader can form finite differences across the quad. The batch marks them so that their results are dropped.

A batch is normally released once it holds eight quads. It is released early, with fewer quads, in two cases. The first is an arriving quad that names a different shader program than the open batch; that quad then opens the next batch. The second is an external flush request. A batch with no quads is never released.

Every stream and the batch output use valid/ready handshakes. A stream's quad is taken on a rising clock edge where both its valid and ready are high. The block may drop a ready when other streams compete or while it is stalled, and `in_ready` depends on `in_valid` within the same cycle. The output batch stays valid and unchanged until `out_ready` is seen high. The input side and the output register are decoupled by one batch only: while a finished batch waits for `out_ready`, no input is taken. The flush request is a plain level, not a handshake.

Top module: `quad_batcher`

## Requirements
- R1: At most one quad is taken per cycle. The grant goes round-robin among the streams whose valid is high, searching upward from the stream after the one that last won. After reset the search starts at stream 0.
- R2: The packing is as follows:
  - Quads fill batch slots 0, 1, 2 and so on in the order they are accepted.
  - Thread 4*q+p of `out_cov` carries bit p of the coverage of slot q: 1 means a covered pixel and 0 means a helper thread.
  - Slot q of the positions sits in `out_x[q*XW +: XW]` and `out_y[q*YW +: YW]`.
  - Coverage bits and positions of slots at or beyond `out_count` are zero.
- R3: When the eighth quad with the open batch's shader identifier is accepted, the batch is valid at the output on the next cycle with `out_count` = 8.
- R4: A quad whose shader identifier differs from that of a non-empty open batch releases the open batch unchanged, with its old count and identifier, on the next cycle. The arriving quad becomes slot 0 of a new batch.
- R5: While `flush_req` is high, no quad is accepted. A non-empty open batch is released as soon as the output register is free or is being emptied in that cycle.
- R6: A batch with zero quads is never presented. A flush with an empty open batch leaves `out_valid` low.
- R7: While `out_valid` is high and `out_ready` is low, the whole output stays stable and every `in_ready` is low.
- R8: When the output hands off a batch in the same cycle that another batch closes, the new batch is valid on the next cycle with no idle cycle in between.
- R9: After reset, `out_valid` is low and the open batch is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_SRC | Per-stream quad valid |
| in_ready | output | NUM_SRC | Per-stream quad accepted this cycle |
| in_x | input | NUM_SRC*XW | Per-stream quad X position |
| in_y | input | NUM_SRC*YW | Per-stream quad Y position |
| in_cov | input | NUM_SRC*4 | Per-stream coverage mask, bit p = pixel p |
| in_sid | input | NUM_SRC*SIDW | Per-stream shader program identifier |
| flush_req | input | 1 | Level request to release the open batch |
| out_valid | output | 1 | Batch valid |
| out_ready | input | 1 | Batch consumer ready |
| out_cov | output | QPB*4 | Thread mask, 1 = covered, 0 = helper |
| out_x | output | QPB*XW | Slot X positions |
| out_y | output | QPB*YW | Slot Y positions |
| out_count | output | $clog2(QPB+1) | Number of quads in the batch |
| out_sid | output | SIDW | Shader identifier of the batch |

## Verification
Two events can land in the same cycle: the consumer taking a waiting batch, and a new batch closing behind it. The bench sets this up by stalling the consumer on a seven-quad batch while a quad for a third shader waits at the input. It then raises `out_ready`, so that the handoff and the shader-switch release hit the same edge. The check is that the waiting quad is taken in that cycle and that the next batch appears on the very next cycle, with the expected identifier and count. The bench also holds a quad at the input while a flush is pending, and checks that the flush wins and the quad waits.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int PIX_PER_QUAD = 4;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/qb_rr_arb.sv
module qb_rr_arb #(
  parameter int N    = 4,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic            advance,
  output logic [N-1:0]    gnt,
  output logic [IDXW-1:0] gnt_idx,
  output logic            gnt_any
);
  logic [IDXW-1:0] last_q;

  always_comb begin
    int c;
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      c = (int'(last_q) + k) % N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IDXW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 last_q <= IDXW'(N - 1);
    else if (advance && gnt_any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/qb_open_batch.sv
module qb_open_batch #(
  parameter int QPB  = 8,
  parameter int XW   = 12,
  parameter int YW   = 12,
  parameter int SIDW = 6,
  parameter int CNTW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              append,
  input  logic              restart,
  input  logic              clear,
  input  logic [XW-1:0]     q_x,
  input  logic [YW-1:0]     q_y,
  input  logic [3:0]        q_cov,
  input  logic [SIDW-1:0]   q_sid,
  output logic [CNTW-1:0]   cnt,
  output logic [SIDW-1:0]   sid,
  output logic [CNTW-1:0]   m_cnt,
  output logic [QPB*XW-1:0] m_x,
  output logic [QPB*YW-1:0] m_y,
  output logic [QPB*4-1:0]  m_cov
);
  logic [CNTW-1:0] cnt_q;
  logic [SIDW-1:0] sid_q;

  assign cnt   = cnt_q;
  assign sid   = sid_q;
  assign m_cnt = cnt_q + CNTW'(append);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sid_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= CNTW'(1);
      sid_q <= q_sid;
    end else if (append) begin
      cnt_q <= cnt_q + CNTW'(1);
      sid_q <= q_sid;
    end
  end

  for (genvar q = 0; q < QPB; q++) begin : g_slot
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [3:0]    cov_q;
    logic          hit;

    assign hit = append && (cnt_q == CNTW'(q));
    assign m_x[q*XW +: XW]  = hit ? q_x   : x_q;
    assign m_y[q*YW +: YW]  = hit ? q_y   : y_q;
    assign m_cov[q*4 +: 4]  = hit ? q_cov : cov_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q   <= '0;
        y_q   <= '0;
        cov_q <= '0;
      end else if (clear) begin
        x_q   <= '0;
        y_q   <= '0;
        cov_q <= '0;
      end else if (restart) begin
        if (q == 0) begin
          x_q   <= q_x;
          y_q   <= q_y;
          cov_q <= q_cov;
        end else begin
          x_q   <= '0;
          y_q   <= '0;
          cov_q <= '0;
        end
      end else if (hit) begin
        x_q   <= q_x;
        y_q   <= q_y;
        cov_q <= q_cov;
      end
    end
  end
endmodule

// File: rtl/qb_out_stage.sv
module qb_out_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] d,
  input  logic          ready,
  output logic          valid,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_batcher.sv
module quad_batcher
  import qb_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int QPB     = 8,
  parameter int XW      = 12,
  parameter int YW      = 12,
  parameter int SIDW    = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           in_valid,
  output logic [NUM_SRC-1:0]           in_ready,
  input  logic [NUM_SRC*XW-1:0]        in_x,
  input  logic [NUM_SRC*YW-1:0]        in_y,
  input  logic [NUM_SRC*4-1:0]         in_cov,
  input  logic [NUM_SRC*SIDW-1:0]      in_sid,
  input  logic                         flush_req,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [QPB*PIX_PER_QUAD-1:0]  out_cov,
  output logic [QPB*XW-1:0]            out_x,
  output logic [QPB*YW-1:0]            out_y,
  output logic [$clog2(QPB+1)-1:0]     out_count,
  output logic [SIDW-1:0]              out_sid
);
  localparam int CNTW    = $clog2(QPB + 1);
  localparam int THREADS = QPB * PIX_PER_QUAD;
  localparam int IDXW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int PW      = THREADS + QPB*XW + QPB*YW + CNTW + SIDW;

  logic [NUM_SRC-1:0] gnt;
  logic [IDXW-1:0]    gnt_idx;
  logic               gnt_any;

  logic               slot_free, accept_en, accept;
  logic               mismatch, append, full_close, flush_close, load;

  logic [XW-1:0]      sel_x;
  logic [YW-1:0]      sel_y;
  logic [3:0]         sel_cov;
  logic [SIDW-1:0]    sel_sid;

  logic [CNTW-1:0]    open_cnt, m_cnt;
  logic [SIDW-1:0]    open_sid;
  logic [QPB*XW-1:0]  m_x;
  logic [QPB*YW-1:0]  m_y;
  logic [THREADS-1:0] m_cov;

  logic [PW-1:0]      pay_d, pay_q;

  qb_rr_arb #(.N(NUM_SRC), .IDXW(IDXW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .advance (accept),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  assign sel_x   = in_x[gnt_idx*XW +: XW];
  assign sel_y   = in_y[gnt_idx*YW +: YW];
  assign sel_cov = in_cov[gnt_idx*4 +: 4];
  assign sel_sid = in_sid[gnt_idx*SIDW +: SIDW];

  assign slot_free   = !out_valid || out_ready;
  assign accept_en   = slot_free && !flush_req;
  assign accept      = accept_en && gnt_any;
  assign mismatch    = accept && (open_cnt != '0) && (sel_sid != open_sid);
  assign append      = accept && !mismatch;
  assign full_close  = append && (open_cnt == CNTW'(QPB - 1));
  assign flush_close = flush_req && slot_free && (open_cnt != '0);
  assign load        = mismatch || full_close || flush_close;

  assign in_ready = gnt & {NUM_SRC{accept_en}};

  qb_open_batch #(
    .QPB(QPB), .XW(XW), .YW(YW), .SIDW(SIDW), .CNTW(CNTW)
  ) u_open (
    .clk     (clk),
    .rst_n   (rst_n),
    .append  (append),
    .restart (mismatch),
    .clear   (full_close || flush_close),
    .q_x     (sel_x),
    .q_y     (sel_y),
    .q_cov   (sel_cov),
    .q_sid   (sel_sid),
    .cnt     (open_cnt),
    .sid     (open_sid),
    .m_cnt   (m_cnt),
    .m_x     (m_x),
    .m_y     (m_y),
    .m_cov   (m_cov)
  );

  assign pay_d = {m_cov, m_x, m_y, m_cnt, open_sid};

  qb_out_stage #(.PW(PW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (pay_d),
    .ready (out_ready),
    .valid (out_valid),
    .q     (pay_q)
  );

  assign {out_cov, out_x, out_y, out_count, out_sid} = pay_q;
endmodule

// File: rtl/qb_checker.sv
module qb_checker #(
  parameter int NUM_SRC = 4,
  parameter int QPB     = 8,
  parameter int XW      = 12,
  parameter int YW      = 12,
  parameter int SIDW    = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_SRC-1:0]       in_ready,
  input logic                     flush_req,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [QPB*4-1:0]         out_cov,
  input logic [QPB*XW-1:0]        out_x,
  input logic [QPB*YW-1:0]        out_y,
  input logic [$clog2(QPB+1)-1:0] out_count,
  input logic [SIDW-1:0]          out_sid
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready)); // R1

  AST_HELPER_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_cov >> (32'(out_count) * 4)) == '0)); // R2

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_count) <= QPB)); // R3

  AST_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> (in_ready == '0)); // R5

  AST_NO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0)); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cov) && $stable(out_x)
      && $stable(out_y) && $stable(out_count) && $stable(out_sid))); // R7

  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (in_ready == '0)); // R7
endmodule

bind quad_batcher qb_checker #(
  .NUM_SRC(NUM_SRC), .QPB(QPB), .XW(XW), .YW(YW), .SIDW(SIDW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .flush_req (flush_req),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_cov   (out_cov),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_count (out_count),
  .out_sid   (out_sid)
);

// File: tb/quad_batcher_tb.sv
module quad_batcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 4;
  localparam int QPB  = 8;
  localparam int XW   = 12;
  localparam int YW   = 12;
  localparam int SIDW = 6;
  localparam int CNTW = $clog2(QPB + 1);
  localparam int NV   = 20;

  // vector fields: {src[1:0], flush_after, cov[3:0], sid[4:0]}
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'b1111, 5'd1}, {2'd1, 1'b0, 4'b0001, 5'd1},
    {2'd2, 1'b0, 4'b0010, 5'd1}, {2'd3, 1'b0, 4'b0100, 5'd1},
    {2'd0, 1'b0, 4'b1000, 5'd1}, {2'd1, 1'b0, 4'b0110, 5'd1},
    {2'd2, 1'b0, 4'b1001, 5'd1}, {2'd3, 1'b0, 4'b1110, 5'd1},
    {2'd1, 1'b0, 4'b0011, 5'd2}, {2'd1, 1'b0, 4'b1100, 5'd2},
    {2'd1, 1'b0, 4'b0101, 5'd2}, {2'd2, 1'b0, 4'b1111, 5'd3},
    {2'd3, 1'b1, 4'b0001, 5'd3}, {2'd0, 1'b0, 4'b1010, 5'd4},
    {2'd2, 1'b0, 4'b0111, 5'd4}, {2'd1, 1'b1, 4'b1011, 5'd4},
    {2'd3, 1'b1, 4'b0000, 5'd4}, {2'd0, 1'b0, 4'b1101, 5'd6},
    {2'd1, 1'b0, 4'b0110, 5'd7}, {2'd2, 1'b1, 4'b1001, 5'd6}
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [NS-1:0]          in_valid = '0;
  logic [NS-1:0]          in_ready;
  logic [NS*XW-1:0]       in_x = '0;
  logic [NS*YW-1:0]       in_y = '0;
  logic [NS*4-1:0]        in_cov = '0;
  logic [NS*SIDW-1:0]     in_sid = '0;
  logic                   flush_req = 1'b0;
  logic                   out_valid;
  logic                   out_ready = 1'b1;
  logic [QPB*4-1:0]       out_cov;
  logic [QPB*XW-1:0]      out_x;
  logic [QPB*YW-1:0]      out_y;
  logic [CNTW-1:0]        out_count;
  logic [SIDW-1:0]        out_sid;

  int checks = 0;
  int errors = 0;

  // bench model of the open batch
  int            m_cnt = 0;
  logic [SIDW-1:0] m_sid = '0;
  logic [XW-1:0] m_xs [QPB];
  logic [YW-1:0] m_ys [QPB];
  logic [3:0]    m_cv [QPB];

  logic [QPB*4-1:0]  e_cov [$];
  logic [QPB*XW-1:0] e_x   [$];
  logic [QPB*YW-1:0] e_y   [$];
  int                e_cnt [$];
  logic [SIDW-1:0]   e_sid [$];
  string             e_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_batcher #(.NUM_SRC(NS), .QPB(QPB), .XW(XW), .YW(YW), .SIDW(SIDW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_cov(in_cov), .in_sid(in_sid),
    .flush_req(flush_req), .out_valid(out_valid), .out_ready(out_ready),
    .out_cov(out_cov), .out_x(out_x), .out_y(out_y),
    .out_count(out_count), .out_sid(out_sid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push_batch(input string tag);
    logic [QPB*4-1:0]  c = '0;
    logic [QPB*XW-1:0] x = '0;
    logic [QPB*YW-1:0] y = '0;
    for (int q = 0; q < m_cnt; q++) begin
      c[q*4 +: 4]   = m_cv[q];
      x[q*XW +: XW] = m_xs[q];
      y[q*YW +: YW] = m_ys[q];
    end
    e_cov.push_back(c); e_x.push_back(x); e_y.push_back(y);
    e_cnt.push_back(m_cnt); e_sid.push_back(m_sid); e_tag.push_back(tag);
    m_cnt = 0;
  endtask

  task automatic model_accept(input logic [XW-1:0] x, input logic [YW-1:0] y,
                              input logic [3:0] cv, input logic [SIDW-1:0] sid);
    if (m_cnt > 0 && sid != m_sid) push_batch("R4");
    m_xs[m_cnt] = x; m_ys[m_cnt] = y; m_cv[m_cnt] = cv; m_sid = sid;
    m_cnt++;
    if (m_cnt == QPB) push_batch("R3");
  endtask

  task automatic drive(input int src, input logic [XW-1:0] x, input logic [YW-1:0] y,
                       input logic [3:0] cv, input logic [SIDW-1:0] sid);
    in_valid[src]            = 1'b1;
    in_x[src*XW +: XW]       = x;
    in_y[src*YW +: YW]       = y;
    in_cov[src*4 +: 4]       = cv;
    in_sid[src*SIDW +: SIDW] = sid;
  endtask

  // called just after a falling edge; returns just after a falling edge
  task automatic send(input int src, input logic [XW-1:0] x, input logic [YW-1:0] y,
                      input logic [3:0] cv, input logic [SIDW-1:0] sid);
    bit got;
    drive(src, x, y, cv, sid);
    for (int w = 0; w < 1000; w++) begin
      #(CLK_PERIOD/4);
      got = in_ready[src];
      @(negedge clk);
      if (got) begin
        model_accept(x, y, cv, sid);
        break;
      end
    end
    in_valid[src] = 1'b0;
  endtask

  task automatic do_flush(input string tag);
    flush_req = 1'b1;
    if (m_cnt > 0) push_batch(tag);
    @(negedge clk);
    flush_req = 1'b0;
  endtask

  // output monitor
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && out_valid && out_ready) begin
      if (e_cnt.size() == 0) begin
        check(1'b0, "R6", "unexpected batch count", 64'(out_count), 64'd0);
      end else begin
        check(out_count == CNTW'(e_cnt[0]), e_tag[0], "batch count",
              64'(out_count), 64'(e_cnt[0]));
        check(out_sid == e_sid[0], e_tag[0], "batch shader id",
              64'(out_sid), 64'(e_sid[0]));
        check(out_cov == e_cov[0], "R2", "thread mask", 64'(out_cov), 64'(e_cov[0]));
        check(out_x == e_x[0] && out_y == e_y[0], "R2", "slot positions X",
              64'(out_x), 64'(e_x[0]));
        void'(e_cov.pop_front()); void'(e_x.pop_front()); void'(e_y.pop_front());
        void'(e_cnt.pop_front()); void'(e_sid.pop_front()); void'(e_tag.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [QPB*4-1:0] held_cov;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == 1'b0, "R9", "out_valid in reset", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #(CLK_PERIOD/4);
    check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
    @(negedge clk);

    // R1: all streams request, grants rotate from stream 0
    for (int s = 0; s < NS; s++) drive(s, XW'(40 + s), YW'(60 + s), 4'b1111, 6'd9);
    for (int k = 0; k < NS; k++) begin
      #(CLK_PERIOD/4);
      check(in_ready == NS'(1 << k), "R1", "round-robin grant",
            64'(in_ready), 64'(1 << k));
      @(negedge clk);
      model_accept(XW'(40 + k), YW'(60 + k), 4'b1111, 6'd9);
      in_valid[k] = 1'b0;
    end

    // R5: flush wins over a waiting quad
    drive(2, XW'(77), YW'(88), 4'b0101, 6'd9);
    flush_req = 1'b1;
    push_batch("R5");
    #(CLK_PERIOD/4);
    check(in_ready == '0, "R5", "in_ready during flush", 64'(in_ready), 64'd0);
    @(negedge clk);
    flush_req = 1'b0;
    in_valid[2] = 1'b0;
    @(negedge clk);

    // R6: flush with empty open batch emits nothing
    do_flush("R6");
    for (int k = 0; k < 3; k++) begin
      #(CLK_PERIOD/4);
      check(out_valid == 1'b0, "R6", "no empty batch", 64'(out_valid), 64'd0);
      @(negedge clk);
    end

    // table walk: full batches, shader switches, flushes
    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][11:10]), XW'(16 + i), YW'(200 + i), VEC[i][8:5],
           SIDW'(VEC[i][4:0]));
      if (VEC[i][9]) do_flush("R5");
    end
    repeat (2) @(negedge clk);

    // R7: back-pressure holds output and stalls inputs
    out_ready = 1'b0;
    for (int i = 0; i < QPB; i++) send(0, XW'(300 + i), YW'(400 + i), 4'(i + 1), 6'd12);
    held_cov = out_cov;
    drive(1, XW'(500), YW'(501), 4'b0011, 6'd12);
    for (int k = 0; k < 3; k++) begin
      #(CLK_PERIOD/4);
      check(in_ready == '0, "R7", "inputs stalled", 64'(in_ready), 64'd0);
      check(out_valid && out_count == CNTW'(QPB) && out_cov == held_cov, "R7",
            "output held", 64'(out_cov), 64'(held_cov));
      @(negedge clk);
    end
    out_ready = 1'b1;
    #(CLK_PERIOD/4);
    check(in_ready[1] == 1'b1, "R7", "input resumes", 64'(in_ready), 64'd2);
    @(negedge clk);
    model_accept(XW'(500), YW'(501), 4'b0011, 6'd12);
    in_valid[1] = 1'b0;

    // R8: handoff and shader-switch release in the same cycle
    for (int i = 0; i < 7; i++) send(2, XW'(600 + i), YW'(700 + i), 4'b1001, 6'd13);
    send(0, XW'(610), YW'(710), 4'b1110, 6'd14);
    out_ready = 1'b0;
    drive(3, XW'(620), YW'(720), 4'b0111, 6'd15);
    #(CLK_PERIOD/4);
    check(in_ready[3] == 1'b0, "R7", "quad waits on stalled output", 64'(in_ready), 64'd0);
    @(negedge clk);
    out_ready = 1'b1;
    #(CLK_PERIOD/4);
    check(in_ready[3] == 1'b1, "R8", "quad taken at handoff", 64'(in_ready), 64'd8);
    @(negedge clk);
    model_accept(XW'(620), YW'(720), 4'b0111, 6'd15);
    in_valid[3] = 1'b0;
    #(CLK_PERIOD/8);
    check(out_valid == 1'b1 && out_sid == 6'd14 && out_count == CNTW'(1), "R8",
          "next batch without gap", 64'(out_sid), 64'd14);
    @(negedge clk);
    do_flush("R5");
    repeat (4) @(negedge clk);

    check(e_cnt.size() == 0, "R2", "all expected batches seen",
          64'(e_cnt.size()), 64'd0);
    finish_run();
  end
endmodule